// File: doc/BRIEF.md
# Comparator Event Interrupt Controller

This block watches the single-bit output of an analog comparator and turns selected transitions of that signal into a sticky event flag and an interrupt request. The raw comparator output first passes through a synchronizer. Edge detection then compares each synchronized sample with the one before it. A two-bit mode field selects which transitions count: any change, only falling edges, only rising edges, or none (a reserved code).

Software reaches the block through one 8-bit control/status register on a simple bus: a write strobe, write data, and a read data output that is always valid. The register holds the event flag, a local interrupt enable, a capture-routing enable and the mode field. It also shows the live synchronized comparator level. Software clears the flag by writing a 1 to it. The interrupt controller clears it when it acknowledges the request. When capture routing is on, the synchronized comparator level also drives an output that can feed a timer's capture front end.

Top module: `cmp_evt_irq`

## Requirements
- R1: While reset is held and on the first cycle after it, rd_data reads 8'h00 and both irq and cap_trig are 0.
- R2: Mode field rd_data[1:0] selects the event: 2'b00 any change of the synchronized input, 2'b01 no event at all, 2'b10 falling edge (1 to 0), 2'b11 rising edge (0 to 1).
- R3: A selected event sets the flag at rd_data[4]. The flag reads 1 after the third rising clock edge that follows a change of cmp_in, and it stays set until it is cleared.
- R4: irq is 1 exactly when the flag, the local enable at bit 3 and the gie input are all 1.
- R5: irq_ack held high at a clock edge clears the flag.
- R6: A write with wr_data[4]=1 clears the flag. A write with wr_data[4]=0 leaves the flag unchanged.
- R7: With the routing bit (bit 2) at 1, cap_trig equals the synchronized input, which is cmp_in delayed by two clock edges. With bit 2 at 0, cap_trig is 0.
- R8: A read-modify-write that reads the flag as 1 and writes the value back with another bit changed clears the flag, and the changed bit takes effect.
- R9: If an event and a clear (acknowledge or write-one) fall on the same clock edge, the flag is 1 after that edge.
- R10: The first synchronized sample after reset produces no event, even if cmp_in was 1 throughout reset.
- R11: rd_data[5] shows the synchronized input and rd_data[7:6] read 0. Writes to bits 7:5 have no effect. Every write loads bits 3:0 from wr_data[3:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_in | input | 1 | Asynchronous comparator output |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| irq | output | 1 | Interrupt request |
| cap_trig | output | 1 | Capture trigger routed to a timer |

## Verification
The hardest case to reach from the ports is an event and a clear landing on the same clock edge. The flag is set three edges after the input moves, so a clear has to be placed at exactly that third edge. The stimulus changes cmp_in on a falling clock edge, counts two more falling edges, and then drives irq_ack or a write-one for a single cycle. This is done while the flag is already set, so a lost event would show up as a cleared flag. The first-sample case after reset is reached by holding cmp_in high throughout reset.

// File: rtl/cmp_evt_pkg.sv
// Shared types and field positions for the comparator event interrupt controller.
// Assumes an 8-bit control/status register.
package cmp_evt_pkg;

    typedef enum logic [1:0] {
        MODE_ANY  = 2'b00,
        MODE_NONE = 2'b01,
        MODE_FALL = 2'b10,
        MODE_RISE = 2'b11
    } evt_mode_e;

    typedef struct packed {
        logic      ie;
        logic      route;
        evt_mode_e mode;
    } ctrl_t;

    localparam int REG_W     = 8;
    localparam int FLAG_BIT  = 4;
    localparam int LIVE_BIT  = 5;
    localparam int CTRL_W    = $bits(ctrl_t);

endpackage

// File: rtl/cmp_sync.sv
// Multi-stage synchronizer for the comparator output. A valid token runs
// alongside the data, so that later logic knows when the last stage holds a
// real sample rather than its reset value. Assumes STAGES >= 2.
module cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic samp,
    output logic samp_vld
);
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] vld_q;

    generate
        if (STAGES < 2) begin : g_bad
            initial $error("cmp_sync needs at least two stages");
        end
    endgenerate

    // Shift the input and the valid token one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            vld_q <= '0;
        end else begin
            sh_q  <= {sh_q[STAGES-2:0], din};
            vld_q <= {vld_q[STAGES-2:0], 1'b1};
        end
    end

    assign samp     = sh_q[STAGES-1];
    assign samp_vld = vld_q[STAGES-1];

    // R10: the valid token never drops once it has been raised.
    a_r10_vld_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        samp_vld |=> samp_vld);
endmodule

// File: rtl/cmp_edge.sv
// Edge detector and mode decoder. It compares the current synchronized sample
// with the previous one. No edge is reported until the previous-sample
// register holds a real sample.
module cmp_edge
    import cmp_evt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      samp,
    input  logic      samp_vld,
    input  evt_mode_e mode,
    output logic      evt
);
    logic prev_q;
    logic prev_vld_q;
    logic rise;
    logic fall;

    // Keep the previous sample and record whether it is a real one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q     <= 1'b0;
            prev_vld_q <= 1'b0;
        end else begin
            prev_q     <= samp;
            prev_vld_q <= samp_vld;
        end
    end

    assign rise = prev_vld_q &  samp & ~prev_q;
    assign fall = prev_vld_q & ~samp &  prev_q;

    // Pick the event that the mode field selects.
    always_comb begin
        unique case (mode)
            MODE_ANY:  evt = rise | fall;
            MODE_FALL: evt = fall;
            MODE_RISE: evt = rise;
            default:   evt = 1'b0;
        endcase
    end

    // R2: the reserved mode never produces an event.
    a_r2_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_NONE) |-> !evt);
    // R10: no event before the previous sample is real.
    a_r10_no_first_evt: assert property (@(posedge clk) disable iff (!rst_n)
        !prev_vld_q |-> !evt);
endmodule

// File: rtl/cmp_ctrl_reg.sv
// Control/status register. It holds the control fields and the sticky event
// flag. An event takes priority over a clear by acknowledge or by write-one.
module cmp_ctrl_reg
    import cmp_evt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [FLAG_BIT:0] wr_bits,
    input  logic        evt,
    input  logic        ack,
    output logic        flag,
    output ctrl_t       ctrl
);
    logic   flag_q;
    ctrl_t  ctrl_q;
    logic   clr;

    assign clr = ack | (wr_en & wr_bits[FLAG_BIT]);

    // Control fields load on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else if (wr_en) ctrl_q <= ctrl_t'(wr_bits[CTRL_W-1:0]);
    end

    // Flag: set by an event, cleared otherwise by acknowledge or write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag_q <= 1'b0;
        else if (evt) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
    end

    assign flag = flag_q;
    assign ctrl = ctrl_q;

    // R3 / R9: an event always leaves the flag set.
    a_r3_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag_q);
    // R5: an acknowledge with no event clears the flag.
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !evt) |=> !flag_q);
    // R6: writing 0 to the flag bit keeps it.
    a_r6_w0_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_bits[FLAG_BIT] && !ack && !evt) |=> (flag_q == $past(flag_q)));
    // R11: the control fields hold when no write occurs.
    a_r11_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/cmp_evt_irq.sv
// Top level of the comparator event interrupt controller. It connects the
// synchronizer, edge detector and register, assembles the read word, and
// gates the interrupt and capture outputs. Assumes cmp_in is asynchronous.
module cmp_evt_irq
    import cmp_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_in,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             gie,
    input  logic             irq_ack,
    output logic             irq,
    output logic             cap_trig
);
    logic  samp;
    logic  samp_vld;
    logic  evt;
    logic  flag;
    ctrl_t ctrl;

    cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (cmp_in),
        .samp     (samp),
        .samp_vld (samp_vld)
    );

    cmp_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .samp     (samp),
        .samp_vld (samp_vld),
        .mode     (ctrl.mode),
        .evt      (evt)
    );

    cmp_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_bits (wr_data[FLAG_BIT:0]),
        .evt     (evt),
        .ack     (irq_ack),
        .flag    (flag),
        .ctrl    (ctrl)
    );

    // Read word: zero upper bits, live level, flag, control fields.
    always_comb begin
        rd_data                   = '0;
        rd_data[LIVE_BIT]         = samp;
        rd_data[FLAG_BIT]         = flag;
        rd_data[CTRL_W-1:0]       = ctrl;
    end

    assign irq      = flag & ctrl.ie & gie;
    assign cap_trig = ctrl.route & samp;

    // R4: a request needs the global enable.
    a_r4_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> gie);
    // R7: capture stays inactive while routing is off.
    a_r7_cap_off: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[2] |-> !cap_trig);
endmodule

// File: tb/cmp_evt_irq_test.sv
// Directed bench for cmp_evt_irq: one task for each scenario.
module cmp_evt_irq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_in = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       gie = 1'b0;
    logic       irq_ack = 1'b0;
    logic [7:0] rd_data;
    logic       irq;
    logic       cap_trig;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cmp_evt_irq uut (
        .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .gie(gie),
        .irq_ack(irq_ack), .irq(irq), .cap_trig(cap_trig)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Change the input and wait until a resulting flag is visible.
    task automatic move_cmp(input logic v);
        @(negedge clk);
        cmp_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (4) @(negedge clk);
        check("R1 in reset", {irq, cap_trig, rd_data[5:0]}, 8'h00);
        check("R1 read", rd_data, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {irq, cap_trig, rd_data[5:0]}, 8'h00);
        repeat (6) @(negedge clk);
        check("R10 no first event", rd_data, 8'h20);
    endtask

    task automatic t_modes;
        for (int m = 0; m < 4; m++) begin
            logic c;
            logic e;
            c = cmp_in;
            wr(8'h10 | 8'(m));
            move_cmp(!c);
            e = (m == 0) || (m == 2 && c) || (m == 3 && !c);
            check($sformatf("R2 R3 mode %0d first edge", m), {7'b0, rd_data[4]}, {7'b0, e});
            wr(8'h10 | 8'(m));
            move_cmp(c);
            e = (m == 0) || (m == 2 && !c) || (m == 3 && c);
            check($sformatf("R2 R3 mode %0d second edge", m), {7'b0, rd_data[4]}, {7'b0, e});
        end
    endtask

    task automatic t_irq_gate;
        wr(8'h10);
        move_cmp(!cmp_in);
        wr(8'h08);
        gie = 1'b0; @(negedge clk);
        check("R4 gie off", {7'b0, irq}, 8'h00);
        gie = 1'b1; @(negedge clk);
        check("R4 all on", {7'b0, irq}, 8'h01);
        wr(8'h00);
        check("R4 ie off", {7'b0, irq}, 8'h00);
        check("R6 write 0 keeps flag", {7'b0, rd_data[4]}, 8'h01);
    endtask

    task automatic t_ack_w1c;
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        check("R5 ack clears", {7'b0, rd_data[4]}, 8'h00);
        move_cmp(!cmp_in);
        wr(8'h10);
        check("R6 write 1 clears", {7'b0, rd_data[4]}, 8'h00);
    endtask

    task automatic t_rmw;
        logic [7:0] v;
        move_cmp(!cmp_in);
        v = rd_data;
        check("R8 flag read as set", {7'b0, v[4]}, 8'h01);
        wr(v | 8'h04);
        check("R8 rmw clears flag", {3'b0, rd_data[4:0]}, {4'b0, v[3:0] | 4'h4});
    endtask

    task automatic t_race;
        wr(8'h00);
        move_cmp(!cmp_in);
        @(negedge clk); cmp_in = !cmp_in;
        repeat (2) @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        check("R9 event beats ack", {7'b0, rd_data[4]}, 8'h01);
        @(negedge clk); cmp_in = !cmp_in;
        repeat (2) @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h10;
        @(negedge clk); wr_en = 1'b0;
        check("R9 event beats write-one", {7'b0, rd_data[4]}, 8'h01);
    endtask

    task automatic t_capture;
        logic c;
        wr(8'h10);
        check("R7 route off", {7'b0, cap_trig}, 8'h00);
        move_cmp(1'b1);
        check("R7 route off input high", {7'b0, cap_trig}, 8'h00);
        wr(8'h04);
        check("R7 route on follows", {7'b0, cap_trig}, 8'h01);
        c = cmp_in;
        @(negedge clk); cmp_in = !c;
        @(negedge clk);
        check("R7 one edge later still old", {7'b0, cap_trig}, {7'b0, c});
        @(negedge clk);
        check("R7 two edges later new", {7'b0, cap_trig}, {7'b0, !c});
    endtask

    task automatic t_upper_bits;
        repeat (3) @(negedge clk);
        wr(8'hE0);
        check("R11 upper bits", rd_data[7:5], {2'b00, cmp_in});
        check("R11 low bits loaded", {4'b0, rd_data[3:0]}, 8'h00);
    endtask

    initial begin
        t_reset;
        t_modes;
        t_irq_gate;
        t_ack_w1c;
        t_rmw;
        t_race;
        t_capture;
        t_upper_bits;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule